// File: doc/BRIEF.md
# Single-Clock Queue with Selectable Read Timing

This block is a first-in first-out queue clocked by one clock. A producer offers a word with `w_en` and it is taken whenever `w_rdy` is high. A consumer takes the oldest word with `r_en` whenever `r_rdy` is high. Both sides see the same occupancy count on their own level output. The depth is a parameter and may be any non-negative integer, including 0 and values that are not powers of two. The storage pointers wrap from the last slot back to slot zero, so no capacity is lost and no rounding takes place.

A single parameter selects how read data is presented. In look-ahead mode the oldest entry is visible on `r_data` whenever the queue is not empty. The read handshake only removes it. In registered mode `r_data` is loaded on the clock edge that follows an accepted read and keeps that word until the next accepted read.

Top module: `qfifo_top`

## Requirements
- R1: `r_rdy` is 1 exactly when occupancy is above zero, and `w_rdy` is 1 exactly when occupancy is below `DEPTH`.
- R2: On each clock edge outside reset, occupancy rises by one on an accepted write (`w_en & w_rdy`) and falls by one on an accepted read (`r_en & r_rdy`). It is unchanged when both happen in the same cycle or when neither does.
- R3: With `LOOKAHEAD=1`, whenever `r_rdy` is 1, `r_data` combinationally shows the oldest stored entry.
- R4: With `LOOKAHEAD=0`, `r_data` takes the popped entry on the clock edge after an accepted read. It holds that value in every cycle without an accepted read.
- R5: Entries leave in the order they were accepted, including entries written back to back and across the pointer wrap from slot `DEPTH-1` to slot 0 at a non-power-of-two depth.
- R6: The reset `rst_n` is synchronous and active low. A clock edge with `rst_n` low clears occupancy to 0, which drives `r_rdy` low. In registered mode the same edge clears `r_data` to 0.
- R7: `r_level` and `w_level` both equal the occupancy. Their width is `$clog2(DEPTH+1)`, with a minimum of 1 bit, so they can carry every value from 0 to `DEPTH`.
- R8: A write offered while full, or a read offered while empty, is ignored. Occupancy, stored contents and `r_data` are left as they were.
- R9: `DEPTH=1` behaves as a one-entry queue. `DEPTH=0` keeps `r_rdy` and `w_rdy` at 0 and both levels at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| w_data | input | WIDTH | Word offered for writing |
| w_en | input | 1 | Write request |
| w_rdy | output | 1 | Queue can take a write this cycle |
| w_level | output | LVL_W | Occupancy as seen by the write side |
| r_data | output | WIDTH | Read data (look-ahead or registered) |
| r_en | input | 1 | Read request |
| r_rdy | output | 1 | Queue holds at least one entry |
| r_level | output | LVL_W | Occupancy as seen by the read side |

## Verification
Four instances share one input stream: depth 5 in look-ahead mode, depth 5 in registered mode, depth 1 and depth 0. A vector walk first fills the depth-5 queue to capacity and then offers a write while full. The overflow word must never appear at the output. Next come simultaneous push and pop both at full and at partial occupancy, which separates a correct refusal from a lost or duplicated count. The walk then refills the queue across the pointer wrap at a non-power-of-two depth and drains it past empty. This shows that order survives the wrap and that a pop while empty leaves the registered data untouched. Directed steps assert reset in the middle of a run with data held, and then check that two back-to-back words come out in order in both read modes.

// File: rtl/qfifo_pkg.sv
// Package: width helpers shared by the queue modules.
// Assumes: depth arguments are non-negative.
package qfifo_pkg;

    // Bits needed to address DEPTH slots (at least 1).
    function automatic int idx_w(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

    // Bits needed to count 0..DEPTH (at least 1).
    function automatic int cnt_w(input int depth);
        return (depth < 1) ? 1 : $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/qfifo_ptr.sv
// Module: modulo slot pointer. Advances by one on step and wraps from
// DEPTH-1 to 0, so any depth uses every slot.
// Assumes: step is only raised while the matching side is allowed to move.
module qfifo_ptr #(
    parameter int DEPTH = 5,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    localparam int          LAST_I = (DEPTH > 0) ? DEPTH - 1 : 0;
    localparam logic [PW-1:0] LAST = PW'(LAST_I);

    // Advance the pointer with wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (step)
            ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
    end
endmodule

// File: rtl/qfifo_store.sv
// Module: slot storage with one write port and one combinational read port.
// Assumes: addresses stay below DEPTH; with DEPTH 0 the read word is zero.
module qfifo_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 5,
    parameter int PW    = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [PW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int SLOTS = (DEPTH > 0) ? DEPTH : 1;

    logic [WIDTH-1:0] mem [SLOTS];

    // Store the accepted word in its slot.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Present the slot under the read pointer.
    always_comb begin
        rdata = (DEPTH == 0) ? '0 : mem[raddr];
    end
endmodule

// File: rtl/qfifo_occ.sv
// Module: occupancy counter and the two ready flags derived from it.
// Assumes: inc is never raised when full and dec never when empty.
module qfifo_occ #(
    parameter int DEPTH = 5,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] occ,
    output logic          not_empty,
    output logic          not_full
);
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    // Track the number of stored entries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ <= '0;
        else
            occ <= occ + CW'(inc) - CW'(dec);
    end

    // Derive the ready flags from the count.
    always_comb begin
        not_empty = (occ != '0);
        not_full  = (DEPTH > 0) && (occ < CAP);
    end
endmodule

// File: rtl/qfifo_top.sv
// Module: single-clock queue. LOOKAHEAD=1 shows the head word
// combinationally; LOOKAHEAD=0 registers the popped word.
// Assumes: one clock, synchronous active-low reset, any DEPTH >= 0.
module qfifo_top
    import qfifo_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 5,
    parameter bit LOOKAHEAD = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WIDTH-1:0]          w_data,
    input  logic                      w_en,
    output logic                      w_rdy,
    output logic [cnt_w(DEPTH)-1:0]   w_level,
    output logic [WIDTH-1:0]          r_data,
    input  logic                      r_en,
    output logic                      r_rdy,
    output logic [cnt_w(DEPTH)-1:0]   r_level
);
    localparam int PW = idx_w(DEPTH);
    localparam int CW = cnt_w(DEPTH);

    logic          push, pop;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ;
    logic [WIDTH-1:0] head;

    // Qualify requests with the ready flags.
    always_comb begin
        push = w_en & w_rdy;
        pop  = r_en & r_rdy;
    end

    qfifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wptr (
        .clk(clk), .rst_n(rst_n), .step(push), .ptr(wr_ptr)
    );

    qfifo_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rptr (
        .clk(clk), .rst_n(rst_n), .step(pop), .ptr(rd_ptr)
    );

    qfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) u_store (
        .clk(clk), .we(push), .waddr(wr_ptr), .wdata(w_data),
        .raddr(rd_ptr), .rdata(head)
    );

    qfifo_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
        .clk(clk), .rst_n(rst_n), .inc(push), .dec(pop),
        .occ(occ), .not_empty(r_rdy), .not_full(w_rdy)
    );

    // Both sides report the same occupancy.
    always_comb begin
        r_level = occ;
        w_level = occ;
    end

    generate
        if (LOOKAHEAD) begin : g_look
            // Head word falls through to the output.
            always_comb r_data = head;
        end else begin : g_reg
            // Capture the popped word on the edge after the read.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    r_data <= '0;
                else if (pop)
                    r_data <= head;
            end
        end
    endgenerate
endmodule

// File: rtl/qfifo_chk.sv
// Module: property checker for qfifo_top, attached by bind.
// Assumes: only the ports of the queue are visible.
module qfifo_chk
    import qfifo_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int DEPTH     = 5,
    parameter bit LOOKAHEAD = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [WIDTH-1:0]        w_data,
    input logic                    w_en,
    input logic                    w_rdy,
    input logic [cnt_w(DEPTH)-1:0] w_level,
    input logic [WIDTH-1:0]        r_data,
    input logic                    r_en,
    input logic                    r_rdy,
    input logic [cnt_w(DEPTH)-1:0] r_level
);
    a_r1_wrdy: assert property (@(posedge clk) disable iff (!rst_n)
        w_rdy == (int'(w_level) < DEPTH));

    a_r1_rrdy: assert property (@(posedge clk) disable iff (!rst_n)
        r_rdy == (w_level != '0));

    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> int'(r_level) == int'($past(r_level))
                 + int'($past(w_en & w_rdy)) - int'($past(r_en & r_rdy)));

    a_r7_same_level: assert property (@(posedge clk) disable iff (!rst_n)
        r_level == w_level);

    a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(r_level) <= DEPTH);

    a_r8_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (w_en && !w_rdy && !(r_en && r_rdy)) |=> $stable(r_level));

    generate
        if (!LOOKAHEAD) begin : g_reg
            a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !(r_en && r_rdy) |=> $stable(r_data));
        end
    endgenerate
endmodule

bind qfifo_top qfifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LOOKAHEAD(LOOKAHEAD)) u_chk (.*);

// File: tb/sim_qfifo_top.sv
// Bench: four queue instances (depth 5 look-ahead, depth 5 registered,
// depth 1, depth 0) driven by one stream and checked against queue models.
module sim_qfifo_top;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] w_data = '0;
    logic w_en = 1'b0, r_en = 1'b0;

    logic [7:0] rd0, rd1, rd2, rd3;
    logic wr0, wr1, wr2, wr3, rr0, rr1, rr2, rr3;
    logic [2:0] wl0, rl0, wl1, rl1;
    logic [0:0] wl2, rl2, wl3, rl3;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] q5[$];
    logic [7:0] q1[$];
    logic [7:0] last5 = '0;

    always #(CLK_P/2) clk = ~clk;

    qfifo_top #(.WIDTH(8), .DEPTH(5), .LOOKAHEAD(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .w_data(w_data), .w_en(w_en), .w_rdy(wr0),
        .w_level(wl0), .r_data(rd0), .r_en(r_en), .r_rdy(rr0), .r_level(rl0));
    qfifo_top #(.WIDTH(8), .DEPTH(5), .LOOKAHEAD(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .w_data(w_data), .w_en(w_en), .w_rdy(wr1),
        .w_level(wl1), .r_data(rd1), .r_en(r_en), .r_rdy(rr1), .r_level(rl1));
    qfifo_top #(.WIDTH(8), .DEPTH(1), .LOOKAHEAD(1'b1)) u2 (
        .clk(clk), .rst_n(rst_n), .w_data(w_data), .w_en(w_en), .w_rdy(wr2),
        .w_level(wl2), .r_data(rd2), .r_en(r_en), .r_rdy(rr2), .r_level(rl2));
    qfifo_top #(.WIDTH(8), .DEPTH(0), .LOOKAHEAD(1'b1)) u3 (
        .clk(clk), .rst_n(rst_n), .w_data(w_data), .w_en(w_en), .w_rdy(wr3),
        .w_level(wl3), .r_data(rd3), .r_en(r_en), .r_rdy(rr3), .r_level(rl3));

    // Vector fields: [9] write, [8] read, [7:0] data.
    localparam logic [9:0] VEC [24] = '{
        {2'b10, 8'hA1}, {2'b10, 8'hA2}, {2'b10, 8'hA3}, {2'b10, 8'hA4},
        {2'b10, 8'hA5}, {2'b10, 8'hEE}, {2'b11, 8'hB1}, {2'b11, 8'hB2},
        {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b11, 8'hB3},
        {2'b10, 8'hB4}, {2'b10, 8'hB5}, {2'b10, 8'hB6}, {2'b10, 8'hB7},
        {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00},
        {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b10, 8'hC1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare all instances with the models (called away from the edge).
    task automatic compare(input string lvl_tag);
        chk(int'(rl0) == q5.size(), lvl_tag, int'(rl0), q5.size());
        chk(int'(rl1) == q5.size(), lvl_tag, int'(rl1), q5.size());
        chk(wl0 == rl0, "R7", int'(wl0), int'(rl0));
        chk(rr0 == (q5.size() > 0), "R1", int'(rr0), int'(q5.size() > 0));
        chk(wr0 == (q5.size() < 5), "R1", int'(wr0), int'(q5.size() < 5));
        if (q5.size() > 0)
            chk(rd0 == q5[0], "R3 R5", int'(rd0), int'(q5[0]));
        chk(rd1 == last5, "R4", int'(rd1), int'(last5));
        chk(int'(rl2) == q1.size(), "R9", int'(rl2), q1.size());
        chk(wr2 == (q1.size() == 0), "R9", int'(wr2), int'(q1.size() == 0));
        if (q1.size() > 0)
            chk(rd2 == q1[0], "R9", int'(rd2), int'(q1[0]));
        chk(!rr3 && !wr3 && rl3 == 0 && wl3 == 0, "R9", int'({rr3, wr3}), 0);
    endtask

    // Apply one cycle of stimulus and update the models.
    task automatic step(input bit we, input bit re, input logic [7:0] d);
        bit w5, r5, w1, r1, refused;
        logic [7:0] pop5;
        w_en = we; r_en = re; w_data = d;
        w5 = we && q5.size() < 5;
        r5 = re && q5.size() > 0;
        w1 = we && q1.size() < 1;
        r1 = re && q1.size() > 0;
        refused = (we && !w5) || (re && !r5);
        pop5 = (q5.size() > 0) ? q5[0] : 8'h00;
        @(posedge clk);
        if (r5) begin void'(q5.pop_front()); last5 = pop5; end
        if (w5) q5.push_back(d);
        if (r1) void'(q1.pop_front());
        if (w1) q1.push_back(d);
        @(negedge clk);
        w_en = 1'b0; r_en = 1'b0;
        compare(refused ? "R8" : "R2");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R6: reset state after edges with rst_n low.
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(rl0 == 0 && !rr0 && wr0, "R6", int'(rl0), 0);
        chk(rd1 == 8'h00, "R6", int'(rd1), 0);
        chk(!wr3 && !rr3, "R9", int'(wr3), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk: fill, overflow, mixed, wrap at depth 5, underflow.
        foreach (VEC[i]) step(VEC[i][9], VEC[i][8], VEC[i][7:0]);

        // R6: reset in the middle of a run with data held.
        step(1'b1, 1'b0, 8'hC2);
        step(1'b1, 1'b0, 8'hC3);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(rl0 == 0 && !rr0, "R6", int'(rl0), 0);
        chk(rl1 == 0 && !rr1 && rd1 == 8'h00, "R6", int'(rd1), 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        q5.delete(); q1.delete(); last5 = '0;
        chk(rl0 == 0 && !rr0, "R6", int'(rl0), 0);

        // R5: back-to-back writes leave back to back in order.
        step(1'b1, 1'b0, 8'hD1);
        step(1'b1, 1'b0, 8'hD2);
        step(1'b0, 1'b1, 8'h00);
        chk(rd1 == 8'hD1, "R5", int'(rd1), 8'hD1);
        step(1'b0, 1'b1, 8'h00);
        chk(rd1 == 8'hD2, "R5", int'(rd1), 8'hD2);
        // R8: read while empty leaves registered data alone.
        step(1'b0, 1'b1, 8'h00);
        chk(rd1 == 8'hD2 && rl1 == 0, "R8", int'(rd1), 8'hD2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule